// File: doc/BRIEF.md
# Serial EEPROM Shadow-RAM Transfer Engine

This block copies whole images between a word-organised three-wire serial EEPROM and the byte-wide shadow RAM that backs the attribute memory space. After reset it fills the shadow RAM from the EEPROM on its own, with no host action. After that, a host command strobe starts either a fresh load, which throws away any unsaved RAM edits, or a save of the complete RAM back into the EEPROM. A save runs only while the write-permit input is high.

Each 16-bit EEPROM word takes two even attribute addresses. Word n puts its low byte at address 4n and its high byte at address 4n+2. The engine never writes odd addresses. On the serial side it drives chip select and a serial clock at the master clock divided by a parameter (32 by default). It shares one data line with the EEPROM. At the pad, the output enable decides which side owns that line.

Top module: `ee_shadow_xfer`

## Requirements
- R1: `ee_sk` toggles only while `ee_cs` is high during a bit frame. Its period is CLK_DIV master clocks, with CLK_DIV/2 cycles low followed by CLK_DIV/2 cycles high. It rests low otherwise.
- R2: After `rst` is released, a full load pass starts without any command. `rd_busy` is high from the second cycle. Command strobes given before that pass ends are discarded.
- R3: EEPROM word n writes its bits 7:0 to RAM address 4n and its bits 15:8 to RAM address 4n+2. The engine never writes any other address (4n+1, 4n+3).
- R4: A `cmd_read` strobe while idle reloads every word from the EEPROM. Any RAM contents at the mapped addresses are overwritten.
- R5: A load pass runs whatever the level of `write_permit`.
- R6: A `cmd_write` strobe while idle with `write_permit` high stores word n = {RAM[4n+2], RAM[4n]} for every n. Exactly one write-enable frame comes before the first word.
- R7: A `cmd_write` strobe with `write_permit` low is discarded. Afterwards `ee_cs` stays low, `wr_busy` stays low and `done` does not pulse.
- R8: During reset, `rd_busy`, `wr_busy`, `done`, `ee_cs` and `ram_we` are low. An accepted strobe raises the matching busy flag on the next cycle. When the pass ends, the flag clears in the same cycle that `done` pulses high for one cycle.
- R9: When `cmd_read` and `cmd_write` arrive together while idle, the load is taken and the save is dropped.
- R10: Every frame is: a start bit of 1, a 2-bit opcode (10 load, 01 store, 00 write-enable with the top two address bits 11), EE_AW address bits MSB first, then 16 data bits MSB first. After each store frame, `ee_cs` goes low, then high again, and the data line is polled until it reads 1. The next frame starts only after that.
- R11: Command strobes that arrive during any pass are discarded. They leave no pending work once the pass ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_read | input | 1 | Strobe: reload shadow RAM from EEPROM |
| cmd_write | input | 1 | Strobe: save shadow RAM to EEPROM |
| write_permit | input | 1 | High allows a save pass |
| rd_busy | output | 1 | Load pass in progress (command bit, self-clearing) |
| wr_busy | output | 1 | Save pass in progress (command bit, self-clearing) |
| done | output | 1 | One-cycle pulse at the end of every pass |
| ram_addr | output | EE_AW+2 | Attribute byte address into shadow RAM |
| ram_wdata | output | 8 | Byte written to shadow RAM |
| ram_we | output | 1 | Shadow RAM write strobe |
| ram_re | output | 1 | Shadow RAM read strobe (data one cycle later) |
| ram_rdata | input | 8 | Shadow RAM read data |
| ee_cs | output | 1 | EEPROM chip select |
| ee_sk | output | 1 | EEPROM serial clock |
| ee_do | output | 1 | Data driven toward the shared line |
| ee_doe | output | 1 | High when the engine owns the shared line |
| ee_di | input | 1 | Level seen on the shared line |

## Verification
A word counter or byte-lane slip inside the engine shows up as shifted or swapped bytes at the even addresses. A slip can also land a stray write on 4n+1 or 4n+3. Either is visible in the RAM image as soon as the first pass completes. A broken bit counter or opcode field makes the EEPROM model decode the wrong frame. That corrupts the whole image or leaves the store count off by the end of the pass. A command gate that leaks shows at the ports within a cycle or two: a busy flag rises, or `ee_cs` goes high, where both must stay low.

// File: rtl/ee_shadow_pkg.sv
`timescale 1ns/1ps
package ee_shadow_pkg;

  typedef enum logic [1:0] {
    OP_EWEN  = 2'b00,
    OP_WRITE = 2'b01,
    OP_READ  = 2'b10
  } ee_op_e;

  typedef enum logic [1:0] {
    FS_IDLE,
    FS_BITS,
    FS_GAP,
    FS_POLL
  } fs_state_e;

  typedef enum logic [3:0] {
    XC_BOOT,
    XC_IDLE,
    XC_RD_ISSUE,
    XC_RD_WAIT,
    XC_RD_HI,
    XC_RD_NEXT,
    XC_EW_ISSUE,
    XC_EW_WAIT,
    XC_WF_LO,
    XC_WF_HI,
    XC_WF_CAPLO,
    XC_WF_CAPHI,
    XC_WR_ISSUE,
    XC_WR_WAIT,
    XC_FINISH
  } xc_state_e;

endpackage

// File: rtl/ee_sk_timer.sv
`timescale 1ns/1ps
// Bit-slot timer: SK low for the first half slot, high for the second.
module ee_sk_timer #(
  parameter int DIV = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic sk,
  output logic bit_end
);
  localparam int CW   = $clog2(DIV);
  localparam int HALF = DIV / 2;

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt <= '0;
      sk  <= 1'b0;
    end else begin
      if (cnt == CW'(DIV - 1)) cnt <= '0;
      else                     cnt <= cnt + CW'(1);
      if (cnt == CW'(HALF - 1))     sk <= 1'b1;
      else if (cnt == CW'(DIV - 1)) sk <= 1'b0;
    end
  end

  assign bit_end = en && (cnt == CW'(DIV - 1));
endmodule

// File: rtl/ee_frame_shifter.sv
`timescale 1ns/1ps
// Shifts one frame out (MSB first), optionally captures trailing input bits,
// then holds CS low for one slot and optionally polls the line for ready.
module ee_frame_shifter
  import ee_shadow_pkg::*;
#(
  parameter int TXW = 27,
  parameter int DIV = 32,
  localparam int NW = $clog2(TXW + 1)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic [TXW-1:0] tx_bits,
  input  logic [NW-1:0]  n_out,
  input  logic [NW-1:0]  n_in,
  input  logic           poll,
  input  logic           di,
  output logic           cs,
  output logic           sk,
  output logic           dout,
  output logic           doe,
  output logic [15:0]    rx,
  output logic           fin
);
  localparam int GW = $clog2(DIV);

  fs_state_e      state;
  logic [TXW-1:0] txsr;
  logic [NW-1:0]  left, nin_r;
  logic           poll_r;
  logic [GW-1:0]  gap;
  logic           bit_end;

  ee_sk_timer #(.DIV(DIV)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .en      (state == FS_BITS),
    .sk      (sk),
    .bit_end (bit_end)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= FS_IDLE;
      txsr   <= '0;
      left   <= '0;
      nin_r  <= '0;
      poll_r <= 1'b0;
      gap    <= '0;
      rx     <= '0;
      cs     <= 1'b0;
      doe    <= 1'b0;
      fin    <= 1'b0;
    end else begin
      fin <= 1'b0;
      case (state)
        FS_IDLE: if (start) begin
          txsr   <= tx_bits;
          left   <= n_out + n_in;
          nin_r  <= n_in;
          poll_r <= poll;
          cs     <= 1'b1;
          doe    <= (n_out != '0);
          state  <= FS_BITS;
        end
        FS_BITS: if (bit_end) begin
          txsr <= {txsr[TXW-2:0], 1'b0};
          if (left <= nin_r) rx <= {rx[14:0], di};
          left <= left - NW'(1);
          if (left - NW'(1) == nin_r) doe <= 1'b0;
          if (left == NW'(1)) begin
            cs    <= 1'b0;
            doe   <= 1'b0;
            gap   <= '0;
            state <= FS_GAP;
          end
        end
        FS_GAP: begin
          gap <= gap + GW'(1);
          if (gap == GW'(DIV - 1)) begin
            gap <= '0;
            if (poll_r) begin
              cs    <= 1'b1;
              state <= FS_POLL;
            end else begin
              fin   <= 1'b1;
              state <= FS_IDLE;
            end
          end
        end
        FS_POLL: begin
          if (gap < GW'(4)) gap <= gap + GW'(1);
          else if (di) begin
            cs     <= 1'b0;
            poll_r <= 1'b0;
            gap    <= '0;
            state  <= FS_GAP;
          end
        end
        default: state <= FS_IDLE;
      endcase
    end
  end

  assign dout = txsr[TXW-1];
endmodule

// File: rtl/ee_xfer_ctrl.sv
`timescale 1ns/1ps
// Pass sequencer: boot load, command load, and write-enabled save.
module ee_xfer_ctrl
  import ee_shadow_pkg::*;
#(
  parameter int AW  = 8,
  localparam int TXW = 3 + AW + 16,
  localparam int NW  = $clog2(TXW + 1)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           cmd_read,
  input  logic           cmd_write,
  input  logic           write_permit,
  input  logic           fs_fin,
  input  logic [15:0]    fs_rx,
  input  logic [7:0]     ram_rdata,
  output logic           fs_start,
  output logic [TXW-1:0] fs_tx,
  output logic [NW-1:0]  fs_nout,
  output logic [NW-1:0]  fs_nin,
  output logic           fs_poll,
  output logic [AW+1:0]  ram_addr,
  output logic [7:0]     ram_wdata,
  output logic           ram_we,
  output logic           ram_re,
  output logic           rd_busy,
  output logic           wr_busy,
  output logic           done
);
  // AW must be at least 3 so the write-enable address keeps a zero field.
  localparam logic [AW-1:0] EWEN_ADDR = {2'b11, {(AW-2){1'b0}}};

  xc_state_e     state;
  logic [AW-1:0] widx;
  logic [7:0]    lo_b, hi_b;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= XC_BOOT;
      widx      <= '0;
      lo_b      <= '0;
      hi_b      <= '0;
      fs_start  <= 1'b0;
      fs_tx     <= '0;
      fs_nout   <= '0;
      fs_nin    <= '0;
      fs_poll   <= 1'b0;
      ram_addr  <= '0;
      ram_wdata <= '0;
      ram_we    <= 1'b0;
      ram_re    <= 1'b0;
      rd_busy   <= 1'b0;
      wr_busy   <= 1'b0;
      done      <= 1'b0;
    end else begin
      fs_start <= 1'b0;
      ram_we   <= 1'b0;
      ram_re   <= 1'b0;
      done     <= 1'b0;
      case (state)
        XC_BOOT: begin
          rd_busy <= 1'b1;
          widx    <= '0;
          state   <= XC_RD_ISSUE;
        end
        XC_IDLE: begin
          if (cmd_read) begin
            rd_busy <= 1'b1;
            widx    <= '0;
            state   <= XC_RD_ISSUE;
          end else if (cmd_write && write_permit) begin
            wr_busy <= 1'b1;
            widx    <= '0;
            state   <= XC_EW_ISSUE;
          end
        end
        XC_RD_ISSUE: begin
          fs_start <= 1'b1;
          fs_tx    <= {1'b1, OP_READ, widx, 16'h0000};
          fs_nout  <= NW'(3 + AW);
          fs_nin   <= NW'(16);
          fs_poll  <= 1'b0;
          state    <= XC_RD_WAIT;
        end
        XC_RD_WAIT: if (fs_fin) begin
          ram_we    <= 1'b1;
          ram_addr  <= {widx, 2'b00};
          ram_wdata <= fs_rx[7:0];
          state     <= XC_RD_HI;
        end
        XC_RD_HI: begin
          ram_we    <= 1'b1;
          ram_addr  <= {widx, 2'b10};
          ram_wdata <= fs_rx[15:8];
          state     <= XC_RD_NEXT;
        end
        XC_RD_NEXT: begin
          if (&widx) state <= XC_FINISH;
          else begin
            widx  <= widx + AW'(1);
            state <= XC_RD_ISSUE;
          end
        end
        XC_EW_ISSUE: begin
          fs_start <= 1'b1;
          fs_tx    <= {1'b1, OP_EWEN, EWEN_ADDR, 16'h0000};
          fs_nout  <= NW'(3 + AW);
          fs_nin   <= '0;
          fs_poll  <= 1'b0;
          state    <= XC_EW_WAIT;
        end
        XC_EW_WAIT: if (fs_fin) state <= XC_WF_LO;
        XC_WF_LO: begin
          ram_re   <= 1'b1;
          ram_addr <= {widx, 2'b00};
          state    <= XC_WF_HI;
        end
        XC_WF_HI: begin
          ram_re   <= 1'b1;
          ram_addr <= {widx, 2'b10};
          state    <= XC_WF_CAPLO;
        end
        XC_WF_CAPLO: begin
          lo_b  <= ram_rdata;
          state <= XC_WF_CAPHI;
        end
        XC_WF_CAPHI: begin
          hi_b  <= ram_rdata;
          state <= XC_WR_ISSUE;
        end
        XC_WR_ISSUE: begin
          fs_start <= 1'b1;
          fs_tx    <= {1'b1, OP_WRITE, widx, hi_b, lo_b};
          fs_nout  <= NW'(TXW);
          fs_nin   <= '0;
          fs_poll  <= 1'b1;
          state    <= XC_WR_WAIT;
        end
        XC_WR_WAIT: if (fs_fin) begin
          if (&widx) state <= XC_FINISH;
          else begin
            widx  <= widx + AW'(1);
            state <= XC_WF_LO;
          end
        end
        XC_FINISH: begin
          rd_busy <= 1'b0;
          wr_busy <= 1'b0;
          done    <= 1'b1;
          state   <= XC_IDLE;
        end
        default: state <= XC_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ee_shadow_xfer.sv
`timescale 1ns/1ps
module ee_shadow_xfer #(
  parameter int EE_AW   = 8,
  parameter int CLK_DIV = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_read,
  input  logic             cmd_write,
  input  logic             write_permit,
  output logic             rd_busy,
  output logic             wr_busy,
  output logic             done,
  output logic [EE_AW+1:0] ram_addr,
  output logic [7:0]       ram_wdata,
  output logic             ram_we,
  output logic             ram_re,
  input  logic [7:0]       ram_rdata,
  output logic             ee_cs,
  output logic             ee_sk,
  output logic             ee_do,
  output logic             ee_doe,
  input  logic             ee_di
);
  localparam int TXW = 3 + EE_AW + 16;
  localparam int NW  = $clog2(TXW + 1);

  logic           fs_start, fs_poll, fs_fin;
  logic [TXW-1:0] fs_tx;
  logic [NW-1:0]  fs_nout, fs_nin;
  logic [15:0]    fs_rx;

  ee_xfer_ctrl #(.AW(EE_AW)) u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .cmd_read     (cmd_read),
    .cmd_write    (cmd_write),
    .write_permit (write_permit),
    .fs_fin       (fs_fin),
    .fs_rx        (fs_rx),
    .ram_rdata    (ram_rdata),
    .fs_start     (fs_start),
    .fs_tx        (fs_tx),
    .fs_nout      (fs_nout),
    .fs_nin       (fs_nin),
    .fs_poll      (fs_poll),
    .ram_addr     (ram_addr),
    .ram_wdata    (ram_wdata),
    .ram_we       (ram_we),
    .ram_re       (ram_re),
    .rd_busy      (rd_busy),
    .wr_busy      (wr_busy),
    .done         (done)
  );

  ee_frame_shifter #(.TXW(TXW), .DIV(CLK_DIV)) u_shift (
    .clk     (clk),
    .rst     (rst),
    .start   (fs_start),
    .tx_bits (fs_tx),
    .n_out   (fs_nout),
    .n_in    (fs_nin),
    .poll    (fs_poll),
    .di      (ee_di),
    .cs      (ee_cs),
    .sk      (ee_sk),
    .dout    (ee_do),
    .doe     (ee_doe),
    .rx      (fs_rx),
    .fin     (fs_fin)
  );
endmodule

// File: rtl/ee_shadow_xfer_chk.sv
`timescale 1ns/1ps
module ee_shadow_xfer_chk #(
  parameter int EE_AW = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             cmd_write,
  input logic             write_permit,
  input logic             rd_busy,
  input logic             wr_busy,
  input logic             done,
  input logic [EE_AW+1:0] ram_addr,
  input logic             ram_we,
  input logic             ram_re,
  input logic             ee_cs,
  input logic             ee_sk,
  input logic             ee_doe
);
  a_r1_sk_needs_cs: assert property (@(posedge clk) disable iff (rst)
    ee_sk |-> ee_cs);

  a_r10_drive_needs_cs: assert property (@(posedge clk) disable iff (rst)
    ee_doe |-> ee_cs);

  a_r3_even_only: assert property (@(posedge clk) disable iff (rst)
    ram_we |-> (ram_addr[0] == 1'b0));

  a_r4_writes_in_load: assert property (@(posedge clk) disable iff (rst)
    ram_we |-> (rd_busy && !ram_re));

  a_r6_reads_in_save: assert property (@(posedge clk) disable iff (rst)
    ram_re |-> wr_busy);

  a_r7_save_needs_permit: assert property (@(posedge clk) disable iff (rst)
    $rose(wr_busy) |-> $past(write_permit));

  a_r8_one_pass: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rd_busy, wr_busy}));

  a_r8_done_ends_pass: assert property (@(posedge clk) disable iff (rst)
    done |-> (!rd_busy && !wr_busy && $past(rd_busy || wr_busy)));

  a_r11_no_save_during_load: assert property (@(posedge clk) disable iff (rst)
    (rd_busy && cmd_write) |=> !wr_busy);
endmodule

bind ee_shadow_xfer ee_shadow_xfer_chk #(.EE_AW(EE_AW)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .cmd_write    (cmd_write),
  .write_permit (write_permit),
  .rd_busy      (rd_busy),
  .wr_busy      (wr_busy),
  .done         (done),
  .ram_addr     (ram_addr),
  .ram_we       (ram_we),
  .ram_re       (ram_re),
  .ee_cs        (ee_cs),
  .ee_sk        (ee_sk),
  .ee_doe       (ee_doe)
);

// File: tb/tb_ee_shadow_xfer.sv
`timescale 1ns/1ps
module tb_ee_shadow_xfer;
  localparam int AW    = 3;
  localparam int DIV   = 32;
  localparam int WORDS = 1 << AW;
  localparam int HW    = 3 + AW;
  localparam int BUSY  = 60;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst, cmd_read, cmd_write, write_permit;
  logic          rd_busy, wr_busy, done, ram_we, ram_re;
  logic [AW+1:0] ram_addr;
  logic [7:0]    ram_wdata, ram_rdata;
  logic          ee_cs, ee_sk, ee_do, ee_doe, ee_di;

  ee_shadow_xfer #(.EE_AW(AW), .CLK_DIV(DIV)) dut (
    .clk(clk), .rst(rst), .cmd_read(cmd_read), .cmd_write(cmd_write),
    .write_permit(write_permit), .rd_busy(rd_busy), .wr_busy(wr_busy),
    .done(done), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
    .ram_we(ram_we), .ram_re(ram_re), .ram_rdata(ram_rdata),
    .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_do(ee_do), .ee_doe(ee_doe),
    .ee_di(ee_di)
  );

  int vectors = 0;
  int miscompares = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // Shadow RAM: synchronous, one-cycle read latency.
  logic [7:0] ram [4*WORDS];
  always @(posedge clk) begin
    if (ram_we) ram[ram_addr] <= ram_wdata;
    if (ram_re) ram_rdata <= ram[ram_addr];
  end

  // Behavioural serial EEPROM on the shared line.
  logic [15:0]   eemem [WORDS];
  logic          sk_q = 1'b0;
  logic [HW-1:0] hdr = '0;
  logic [1:0]    m_op = 2'b11;
  logic [AW-1:0] m_addr = '0;
  logic [15:0]   m_data = '0;
  logic          m_wen = 1'b0, m_out = 1'b1, m_drv = 1'b0, m_wr_pend = 1'b0;
  int m_cnt = 0, m_busy = 0, wr_count = 0, ewen_count = 0, bad_frames = 0, busy_viol = 0;

  assign ee_di = ee_doe ? ee_do : (m_drv ? m_out : 1'b1);

  always @(posedge clk) begin
    logic [HW-1:0] full;
    sk_q <= ee_sk;
    if (m_busy > 0) m_busy <= m_busy - 1;
    if (!ee_cs) begin
      if (m_wr_pend) begin
        if (m_cnt == HW + 16 && m_wen) begin
          eemem[m_addr] <= m_data;
          wr_count++;
          m_busy <= BUSY;
        end
        m_wr_pend <= 1'b0;
      end
      m_cnt <= 0;
      m_drv <= 1'b0;
      m_op  <= 2'b11;
    end else if (ee_sk && !sk_q) begin
      if (m_cnt == 0 && m_busy > 0) busy_viol++;
      if (m_cnt < HW) begin
        full = {hdr[HW-2:0], ee_di};
        hdr <= full;
        if (m_cnt == HW - 1) begin
          if (!full[HW-1]) bad_frames++;
          m_op   <= full[AW+1:AW];
          m_addr <= full[AW-1:0];
          if (full[AW+1:AW] == 2'b00) begin
            if (full[AW-1:AW-2] == 2'b11) begin m_wen <= 1'b1; ewen_count++; end
            else bad_frames++;
          end
          if (full[AW+1:AW] == 2'b01) m_wr_pend <= 1'b1;
          if (full[AW+1:AW] == 2'b11) bad_frames++;
        end
      end else if (m_cnt < HW + 16) begin
        if (m_op == 2'b10) begin
          m_drv <= 1'b1;
          m_out <= eemem[m_addr][15 - (m_cnt - HW)];
        end else if (m_op == 2'b01) m_data <= {m_data[14:0], ee_di};
      end
      m_cnt <= m_cnt + 1;
    end else if (m_cnt == 0) begin
      m_drv <= 1'b1;
      m_out <= (m_busy == 0);
    end
  end

  function automatic logic [15:0] pat(input int n, input logic [15:0] seed);
    return 16'(n * 40503) ^ seed ^ 16'(n << 9);
  endfunction

  task automatic wait_done(input string tag);
    bit seen = 0;
    for (int i = 0; i < 40000 && !seen; i++) begin
      @(negedge clk);
      if (done) seen = 1;
    end
    chk(seen, {tag, " done pulse"}, int'(seen), 1);
  endtask

  task automatic check_ram(input logic [15:0] seed, input string tag);
    for (int a = 0; a < 4*WORDS; a++) begin
      int exp;
      case (a % 4)
        0:       exp = int'(pat(a/4, seed) & 16'h00ff);
        2:       exp = int'(pat(a/4, seed) >> 8);
        default: exp = 8'hEE;
      endcase
      chk(ram[a] == 8'(exp), tag, int'(ram[a]), exp);
    end
  endtask

  task automatic pulse(input bit rd, input bit wr);
    cmd_read = rd; cmd_write = wr;
    @(negedge clk);
    cmd_read = 0; cmd_write = 0;
  endtask

  task automatic quiet(input int n, input string tag);
    bit bad = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (ee_cs || ee_sk || rd_busy || wr_busy || done) bad = 1;
    end
    chk(!bad, tag, int'(bad), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    int hi_cnt, per_cnt, wr_before;
    rst = 1; cmd_read = 0; cmd_write = 0; write_permit = 0;
    for (int n = 0; n < WORDS; n++) eemem[n] = pat(n, 16'hA5C3);
    for (int a = 0; a < 4*WORDS; a++) ram[a] = 8'hEE;
    repeat (5) @(negedge clk);
    // R8 reset state
    chk(!rd_busy && !wr_busy && !done && !ee_cs && !ram_we, "R8 reset outputs",
        {rd_busy, wr_busy, done, ee_cs, ram_we}, 0);
    // R2: commands offered from reset release on are discarded during boot
    rst = 0; cmd_write = 1; write_permit = 1;
    @(negedge clk); @(negedge clk);
    chk(rd_busy && !wr_busy, "R2 boot load starts alone", {rd_busy, wr_busy}, 2);
    cmd_write = 0; write_permit = 0;

    // R1: serial clock shape
    while (!ee_sk) @(negedge clk);
    hi_cnt = 0; while (ee_sk) begin hi_cnt++; @(negedge clk); end
    per_cnt = hi_cnt; while (!ee_sk) begin per_cnt++; @(negedge clk); end
    chk(hi_cnt == DIV/2, "R1 sk high time", hi_cnt, DIV/2);
    chk(per_cnt == DIV, "R1 sk period", per_cnt, DIV);

    wait_done("R2 boot");
    chk(!rd_busy, "R8 rd_busy cleared with done", int'(rd_busy), 0);
    check_ram(16'hA5C3, "R2 R3 boot image");
    chk(wr_count == 0, "R2 boot-time save ignored", wr_count, 0);
    quiet(300, "R11 no pending work after boot");

    // R4 R5: reload overwrites edits, permit low
    for (int n = 0; n < WORDS; n++) begin
      ram[4*n] = 8'h11; ram[4*n+2] = 8'h22;
      eemem[n] = pat(n, 16'h3C96);
    end
    write_permit = 0;
    pulse(1, 0);
    chk(rd_busy && !wr_busy, "R8 R5 load accepted", {rd_busy, wr_busy}, 2);
    wait_done("R4 reload");
    check_ram(16'h3C96, "R4 R5 reload image");

    // R7: save refused without permit
    for (int n = 0; n < WORDS; n++) begin
      ram[4*n] = 8'(pat(n, 16'h5A0F)); ram[4*n+2] = 8'(pat(n, 16'h5A0F) >> 8);
    end
    pulse(0, 1);
    quiet(3*DIV*4, "R7 refused save stays silent");
    for (int n = 0; n < WORDS; n++)
      chk(eemem[n] == pat(n, 16'h3C96), "R7 eeprom unchanged", int'(eemem[n]), int'(pat(n, 16'h3C96)));

    // R6 R10 R11: permitted save, with a load strobe during the pass
    write_permit = 1;
    pulse(0, 1);
    chk(wr_busy && !rd_busy, "R8 R6 save accepted", {rd_busy, wr_busy}, 1);
    repeat (100) @(negedge clk);
    pulse(1, 0);
    chk(!rd_busy && wr_busy, "R11 load ignored during save", {rd_busy, wr_busy}, 1);
    wait_done("R6 save");
    for (int n = 0; n < WORDS; n++)
      chk(eemem[n] == pat(n, 16'h5A0F), "R6 stored word", int'(eemem[n]), int'(pat(n, 16'h5A0F)));
    chk(wr_count == WORDS, "R6 store frame count", wr_count, WORDS);
    chk(ewen_count == 1, "R6 R10 single write-enable", ewen_count, 1);
    chk(bad_frames == 0, "R10 frame format", bad_frames, 0);
    chk(busy_viol == 0, "R10 ready poll before next frame", busy_viol, 0);
    write_permit = 0;
    quiet(300, "R11 no pending load after save");

    // R9: simultaneous strobes, load wins
    for (int n = 0; n < WORDS; n++) eemem[n] = pat(n, 16'hC001);
    wr_before = wr_count;
    write_permit = 1;
    pulse(1, 1);
    chk(rd_busy && !wr_busy, "R9 load wins", {rd_busy, wr_busy}, 2);
    wait_done("R9 load");
    check_ram(16'hC001, "R9 image after tie");
    chk(wr_count == wr_before, "R9 save dropped", wr_count, wr_before);
    quiet(300, "R9 no save after tie");

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule